// File: doc/BRIEF.md
# Dual-Wave Bus Arbiter

This block is the central arbiter of a shared multidrop bus whose nodes sit in a line along the wire, with node index equal to position. Every node may raise a request that carries the index of its destination. In each cycle the arbiter looks at the requests and picks one transmitter/receiver pair. In the same cycle it may pick a second pair when the two pulse trains are far enough apart on the wire that neither crosses an active endpoint. Each chosen transmitter gets a grant pulse. Only the chosen receivers get a wake-up pulse.

Both outputs are registered. Requests sampled at a clock edge produce their grant and wake-up pulses just after that same edge, and the pulses last one cycle. A granted node keeps its request up and raises its busy input until its transfer has finished. While a node is busy, or in the cycle right after it was granted or woken, it cannot be chosen as a transmitter or as a receiver.

Top module: `dual_wave_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `tx_grant` and `rx_wake` are all zero.
- R2: A request is never granted when its destination equals the requester's own index or is not below NUM_NODES. The destination is an unsigned binary node index in a field of clog2(NUM_NODES)+1 bits, and node i uses bits [i*W +: W] of `req_dest`.
- R3: A node whose `busy` bit is high in the sampling cycle, or which was granted or woken in the previous cycle, takes no part in the new grants. This holds when it is the requester and when it is the destination.
- R4: The first pair goes to the eligible requester with the lowest index.
- R5: At most two transmitters are granted in any cycle, and the number of woken receivers equals the number of granted transmitters.
- R6: A second pair is granted only when 2*|Tx1-Tx0| > NUM_NODES and 2*|Rx1-Rx0| > NUM_NODES.
- R7: No node is both transmitter and receiver in one cycle. The second pair's transmitter is never the first pair's receiver, and its receiver is never the first pair's transmitter.
- R8: The candidates for the second pair are scanned in rotating order starting at the index after the first winner. The first one that passes R2, R3, R6 and R7 is taken.
- R9: The grant and wake-up pulses appear just after the edge that samples the requests and last exactly one cycle.
- R10: `rx_wake` is set only at the destination index of each granted transfer. Every other receiver bit stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_NODES | One request bit per node |
| req_dest | input | NUM_NODES*(clog2(NUM_NODES)+1) | Destination index of each node's request |
| busy | input | NUM_NODES | Node is in a transfer, either sending or receiving |
| tx_grant | output | NUM_NODES | Registered one-cycle grant pulse to each chosen transmitter |
| rx_wake | output | NUM_NODES | Registered one-cycle wake-up pulse to each chosen receiver |

## Verification
The assertions assume that a node sees its grant or wake-up pulse and then raises `busy` from the next sampling edge onward. They also assume that a granted transmitter holds its request until that busy period ends. Under these assumptions, exclusion by busy and by the previous pulse keeps every node in at most one transfer at a time. The random stimulus follows this handshake exactly: each pulse starts a busy period of random length for the node, and a transmitter drops its request in the cycle its busy period ends. New requests, including ones addressed to the node itself or to a nonexistent node, are raised only by nodes that have no request pending.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  // True when two bus positions are more than half the bus length apart.
  function automatic bit far_apart(input int a, input int b, input int n);
    int d;
    d = (a > b) ? (a - b) : (b - a);
    return (2 * d) > n;
  endfunction

endpackage

// File: rtl/dwa_req_filter.sv
module dwa_req_filter #(
  parameter int NUM_NODES = 16,
  parameter int DEST_W    = $clog2(NUM_NODES) + 1
) (
  input  logic [NUM_NODES-1:0]             req_valid,
  input  logic [NUM_NODES-1:0][DEST_W-1:0] dest_arr,
  input  logic [NUM_NODES-1:0]             excl,
  output logic [NUM_NODES-1:0]             cand
);

  for (genvar g = 0; g < NUM_NODES; g++) begin : g_node
    logic in_range;
    logic to_self;
    logic target_excl;

    assign in_range = dest_arr[g] < DEST_W'(NUM_NODES);
    assign to_self  = dest_arr[g] == DEST_W'(g);

    always_comb begin
      target_excl = 1'b0;
      for (int k = 0; k < NUM_NODES; k++) begin
        if (dest_arr[g] == DEST_W'(k) && excl[k]) target_excl = 1'b1;
      end
    end

    assign cand[g] = req_valid[g] & in_range & ~to_self & ~excl[g] & ~target_excl;
  end

endmodule

// File: rtl/dwa_first_pick.sv
module dwa_first_pick #(
  parameter int NUM_NODES = 16,
  parameter int IDX_W     = $clog2(NUM_NODES)
) (
  input  logic [NUM_NODES-1:0] cand,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);

  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_NODES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/dwa_second_pick.sv
module dwa_second_pick
  import dwa_pkg::*;
#(
  parameter int NUM_NODES = 16,
  parameter int IDX_W     = $clog2(NUM_NODES),
  parameter int DEST_W    = IDX_W + 1
) (
  input  logic [NUM_NODES-1:0]             cand,
  input  logic [NUM_NODES-1:0][DEST_W-1:0] dest_arr,
  input  logic                             found0,
  input  logic [IDX_W-1:0]                 idx0,
  input  logic [DEST_W-1:0]                dest0,
  output logic                             found1,
  output logic [IDX_W-1:0]                 idx1
);

  always_comb begin
    int t0;
    int r0;
    int j;
    int rj;
    found1 = 1'b0;
    idx1   = '0;
    t0     = int'(idx0);
    r0     = int'(dest0);
    for (int k = 1; k < NUM_NODES; k++) begin
      j  = (t0 + k) % NUM_NODES;
      rj = int'(dest_arr[j]);
      if (!found1 && found0 && cand[j] &&
          far_apart(j, t0, NUM_NODES) && far_apart(rj, r0, NUM_NODES) &&
          (j != r0) && (rj != t0)) begin
        found1 = 1'b1;
        idx1   = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/dual_wave_arbiter.sv
module dual_wave_arbiter #(
  parameter int NUM_NODES = 16,
  localparam int IDX_W    = $clog2(NUM_NODES),
  localparam int DEST_W   = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_NODES-1:0]        req_valid,
  input  logic [NUM_NODES*DEST_W-1:0] req_dest,
  input  logic [NUM_NODES-1:0]        busy,
  output logic [NUM_NODES-1:0]        tx_grant,
  output logic [NUM_NODES-1:0]        rx_wake
);

  logic [NUM_NODES-1:0][DEST_W-1:0] dest_arr;
  logic [NUM_NODES-1:0]             excl;
  logic [NUM_NODES-1:0]             cand;
  logic                             found0;
  logic                             found1;
  logic [IDX_W-1:0]                 idx0;
  logic [IDX_W-1:0]                 idx1;
  logic [DEST_W-1:0]                dest0;
  logic [DEST_W-1:0]                dest1;
  logic [NUM_NODES-1:0]             tx_d;
  logic [NUM_NODES-1:0]             rx_d;
  logic [NUM_NODES-1:0]             tx_q;
  logic [NUM_NODES-1:0]             rx_q;

  assign dest_arr = req_dest;
  assign excl     = busy | tx_q | rx_q;

  dwa_req_filter #(.NUM_NODES(NUM_NODES), .DEST_W(DEST_W)) filt_i (
    .req_valid (req_valid),
    .dest_arr  (dest_arr),
    .excl      (excl),
    .cand      (cand)
  );

  dwa_first_pick #(.NUM_NODES(NUM_NODES), .IDX_W(IDX_W)) first_i (
    .cand  (cand),
    .found (found0),
    .idx   (idx0)
  );

  assign dest0 = dest_arr[idx0];

  dwa_second_pick #(.NUM_NODES(NUM_NODES), .IDX_W(IDX_W), .DEST_W(DEST_W)) second_i (
    .cand     (cand),
    .dest_arr (dest_arr),
    .found0   (found0),
    .idx0     (idx0),
    .dest0    (dest0),
    .found1   (found1),
    .idx1     (idx1)
  );

  assign dest1 = dest_arr[idx1];

  always_comb begin
    tx_d = '0;
    rx_d = '0;
    if (found0) tx_d[idx0] = 1'b1;
    if (found1) tx_d[idx1] = 1'b1;
    for (int i = 0; i < NUM_NODES; i++) begin
      if ((found0 && dest0 == DEST_W'(i)) || (found1 && dest1 == DEST_W'(i)))
        rx_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_grant = tx_q;
  assign rx_wake  = rx_q;

endmodule

// File: rtl/dwa_checker.sv
module dwa_checker #(
  parameter int NUM_NODES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_NODES-1:0] req_valid,
  input logic [NUM_NODES-1:0] busy,
  input logic [NUM_NODES-1:0] tx_grant,
  input logic [NUM_NODES-1:0] rx_wake
);

  int tx_lo, tx_hi, rx_lo, rx_hi;

  always_comb begin
    tx_lo = 0; tx_hi = 0; rx_lo = 0; rx_hi = 0;
    for (int i = NUM_NODES - 1; i >= 0; i--) begin
      if (tx_grant[i]) tx_lo = i;
      if (rx_wake[i])  rx_lo = i;
    end
    for (int i = 0; i < NUM_NODES; i++) begin
      if (tx_grant[i]) tx_hi = i;
      if (rx_wake[i])  rx_hi = i;
    end
  end

  AST_PAIR_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $countones(tx_grant) <= 2); // R5
  AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(tx_grant) == $countones(rx_wake)); // R5
  AST_ROLE_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (tx_grant & rx_wake) == '0); // R7
  AST_BUSY_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
    ((tx_grant | rx_wake) & $past(busy)) == '0); // R3
  AST_TX_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    (tx_grant & ~$past(req_valid)) == '0); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (|(tx_grant | rx_wake)) |=> ((tx_grant | rx_wake) & $past(tx_grant | rx_wake)) == '0); // R9
  AST_SEPARATION: assert property (@(posedge clk) disable iff (rst)
    ($countones(tx_grant) == 2) |-> ((2 * (tx_hi - tx_lo) > NUM_NODES) &&
                                     (2 * (rx_hi - rx_lo) > NUM_NODES))); // R6

endmodule

bind dual_wave_arbiter dwa_checker #(.NUM_NODES(NUM_NODES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .tx_grant  (tx_grant),
  .rx_wake   (rx_wake)
);

// File: tb/dual_wave_arbiter_tb_top.sv
`timescale 1ns/1ps
module dual_wave_arbiter_tb_top;

  localparam int N  = 16;
  localparam int DW = $clog2(N) + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_valid = '0;
  logic [N*DW-1:0] req_dest = '0;
  logic [N-1:0]    busy = '0;
  logic [N-1:0]    tx_grant;
  logic [N-1:0]    rx_wake;

  int  dst [N];
  int  cnt [N];
  bit  was_tx [N];
  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #10 clk = ~clk;

  dual_wave_arbiter #(.NUM_NODES(N)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
    .busy(busy), .tx_grant(tx_grant), .rx_wake(rx_wake)
  );

  function automatic logic [N-1:0] bits2(input int a, input int b);
    logic [N-1:0] m;
    m = '0;
    if (a >= 0) m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    return m;
  endfunction

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Expected grants from the requirements (R2, R3, R4, R6, R7, R8, R10).
  function automatic void model(input logic [N-1:0] v, input logic [N-1:0] b,
                                input logic [N-1:0] pt, input logic [N-1:0] pr,
                                output logic [N-1:0] et, output logic [N-1:0] er);
    logic [N-1:0] ex, ok;
    int w0, r0;
    ex = b | pt | pr;
    et = '0; er = '0;
    for (int i = 0; i < N; i++)
      ok[i] = v[i] && dst[i] < N && dst[i] != i && !ex[i] && !ex[dst[i] % N];
    w0 = -1;
    for (int i = 0; i < N; i++) if (ok[i] && w0 < 0) w0 = i;
    if (w0 >= 0) begin
      r0 = dst[w0];
      et[w0] = 1'b1; er[r0] = 1'b1;
      for (int k = 1; k < N; k++) begin
        int j;
        j = (w0 + k) % N;
        if (ok[j] && 2*absd(j, w0) > N && 2*absd(dst[j], r0) > N && j != r0 && dst[j] != w0) begin
          et[j] = 1'b1; er[dst[j]] = 1'b1;
          break;
        end
      end
    end
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pack();
    for (int i = 0; i < N; i++) req_dest[i*DW +: DW] = DW'(dst[i]);
  endtask

  task automatic clear_reqs();
    req_valid = '0; busy = '0;
    for (int i = 0; i < N; i++) dst[i] = 0;
    pack();
  endtask

  task automatic set_req(input int s, input int d);
    req_valid[s] = 1'b1; dst[s] = d;
    pack();
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pt, pr, et, er;
    void'($urandom(32'd20240611));
    clear_reqs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tx_grant in reset", tx_grant, '0);
    chk("R1 rx_wake in reset", rx_wake, '0);
    rst = 1'b0;
    cycle();
    chk("R1 tx_grant after reset", tx_grant, '0);

    // Two pairs; node 8 fails the half-length test, node 9 passes
    set_req(0, 15); set_req(9, 5); set_req(8, 7);
    cycle();
    chk("R4 R8 tx two pairs", tx_grant, bits2(0, 9));
    chk("R10 rx two pairs", rx_wake, bits2(15, 5));
    clear_reqs(); cycle();
    chk("R9 pulse lasts one cycle", tx_grant | rx_wake, '0);

    // Self and out-of-range destinations are ignored
    set_req(3, 3); set_req(4, 20); set_req(5, 2);
    cycle();
    chk("R2 tx skips bad destinations", tx_grant, bits2(5, -1));
    chk("R2 rx skips bad destinations", rx_wake, bits2(2, -1));
    clear_reqs(); cycle();

    // Busy requester and busy destination
    busy[1] = 1'b1;
    set_req(1, 12); set_req(2, 1); set_req(6, 14);
    cycle();
    chk("R3 tx busy excluded", tx_grant, bits2(6, -1));
    chk("R3 rx busy excluded", rx_wake, bits2(14, -1));
    clear_reqs(); cycle();

    // Swapped endpoints are far apart but share nodes
    set_req(0, 15); set_req(15, 0);
    cycle();
    chk("R7 tx no shared endpoint", tx_grant, bits2(0, -1));
    chk("R7 rx no shared endpoint", rx_wake, bits2(15, -1));
    clear_reqs(); cycle();

    // Rotation takes the first passing node after the winner
    set_req(3, 14); set_req(12, 1); set_req(13, 0);
    cycle();
    chk("R8 tx rotating scan", tx_grant, bits2(3, 12));
    chk("R6 rx rotating scan", rx_wake, bits2(14, 1));
    clear_reqs(); cycle();

    // A node granted in the last cycle sits out one cycle
    set_req(0, 15);
    cycle();
    chk("R9 grant after one edge", tx_grant, bits2(0, -1));
    cycle();
    chk("R3 just-granted excluded", tx_grant | rx_wake, '0);
    cycle();
    chk("R3 granted again", tx_grant, bits2(0, -1));
    clear_reqs(); cycle();

    // Random traffic following the busy handshake
    pt = '0; pr = '0;
    for (int i = 0; i < N; i++) begin cnt[i] = 0; was_tx[i] = 0; end
    for (int it = 0; it < 3000; it++) begin
      model(req_valid, busy, pt, pr, et, er);
      cycle();
      chk("R4 R8 random tx", tx_grant, et);
      chk("R10 random rx", rx_wake, er);
      n_tests++;
      if ($countones(tx_grant) > 2) begin
        n_fail++;
        $display("FAIL R5 pair count actual=%0d expected<=2", $countones(tx_grant));
      end
      chk("R7 random role overlap", tx_grant & rx_wake, '0);
      pt = et; pr = er;
      for (int i = 0; i < N; i++) begin
        if (et[i]) was_tx[i] = 1;
        if (et[i] || er[i]) cnt[i] = 1 + int'($urandom % 5);
      end
      for (int i = 0; i < N; i++) begin
        busy[i] = cnt[i] > 0;
        if (cnt[i] > 0) cnt[i]--;
        if (was_tx[i] && !busy[i]) begin
          req_valid[i] = 1'b0; was_tx[i] = 0;
        end else if (!req_valid[i]) begin
          if ($urandom % 3 == 0) begin
            req_valid[i] = 1'b1; dst[i] = int'($urandom % 20);
          end
        end else if (!was_tx[i] && $urandom % 8 == 0) begin
          req_valid[i] = 1'b0;
        end
      end
      pack();
    end

    done = 1;
    summary();
    $finish;
  end

endmodule